// File: doc/BRIEF.md
# Fourth-Order Multibit Delta-Sigma Modulator for an Oversampling DAC

This block reshapes a stream of 14-bit two's-complement samples, already interpolated to twelve times the Nyquist rate, into a 6-bit word whose quantization noise is pushed out of the signal band. Four integrators run in a cascade. Every gain in the loop is a power of two and is built as an arithmetic shift, so the block has no multiplier. The quantizer does no arithmetic: it keeps the upper six bits of the last integrator's 20-bit state. That truncated value is scaled and subtracted at the input of every integrator.

Each integrator reads only registered values from its neighbours. The longest path is therefore one three-input adder followed by a saturating clamp. The 6-bit result is registered and also driven out directly, so the digital section can be checked without the analog array. A binary-to-thermometer decoder, registered in the same stage, turns the 6-bit word into 63 enables for identical unit current cells.

A sample is accepted on each cycle that `smp_valid` is high. The matching output word appears two clock edges later, marked by `code_valid`.

Top module: `dsm4_core`

## Requirements
- R1: After reset all four integrator states are zero. `code_valid` is 0, `code_out` is 32 and `cell_en` has ones in bits 0 to 31 only. The first sample after reset is therefore processed from zero state.
- R2: The input sample is weighted by 64 before it enters the first integrator. That is, it sits in the upper 14 bits of the 20-bit datapath.
- R3: On an accepted sample every integrator updates at the same clock edge, using the pre-edge values of all states. The updates are: a1 += x*64 − F; a2 += (a1>>>1) − (F>>>1); a3 += (a2>>>2) − (F>>>2); a4 += (a3>>>2) − (F>>>3). Here `>>>` is a floor (arithmetic) shift.
- R4: Each integrator saturates at +524287 and −524288 instead of wrapping.
- R5: The feedback F is q·16384. Here q is the signed value of bits 19..14 of the pre-edge fourth-integrator state, in the range −32 to 31.
- R6: `code_out` is the offset-binary value q'+32 with 0 ≤ `code_out` ≤ 63. Here q' is bits 19..14 of the fourth integrator after the update. It is registered one cycle after the update edge, and `code_valid` is high for exactly that cycle.
- R7: `cell_en` has exactly `code_out` ones, filled from bit 0 upward. It changes in the same cycle as `code_out`.
- R8: While `smp_valid` is low the integrator states, `code_out` and `cell_en` hold their values, and `code_valid` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe, one sample per high cycle |
| smp_data | input | 14 | Oversampled two's-complement input sample |
| code_valid | output | 1 | Marks a new modulator word |
| code_out | output | 6 | Offset-binary modulator word |
| cell_en | output | 63 | Thermometer enables for the unit cells |

## Verification
The assertions assume that `smp_data` is stable and defined whenever `smp_valid` is high, and that reset is held for at least one edge. The saturation property also assumes that the loop can drive an integrator against either limit. The stimulus changes inputs only on falling edges and raises `smp_valid` for one cycle per sample. It includes full-scale negative and positive inputs so that the clamps are actually reached. A reference model built from the recurrences above predicts every output word, including the saturated cases.

// File: rtl/dsm4_pkg.sv
package dsm4_pkg;
    localparam int DSM_IN_W   = 14;
    localparam int DSM_ACC_W  = 20;
    localparam int DSM_QNT_W  = 6;
    localparam int DSM_ORDER  = 4;

    // Forward gain between stages, as a right shift (stage 0 takes the input).
    function automatic int fwd_shift(input int stage);
        if (stage == 0) return 0;
        else if (stage == 1) return 1;
        else return 2;
    endfunction

    // Feedback gain into each stage, as a right shift.
    function automatic int fb_shift(input int stage);
        return stage;
    endfunction
endpackage

// File: rtl/dsm4_integrator.sv
module dsm4_integrator #(
    parameter int ACC_W  = 20,
    parameter int FWD_SH = 0,
    parameter int FB_SH  = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    input  logic signed [ACC_W-1:0] fwd_i,
    input  logic signed [ACC_W-1:0] fb_i,
    output logic signed [ACC_W-1:0] acc_o
);
    localparam int SUM_W = ACC_W + 2;
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'sd1 <<< (ACC_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

    logic signed [ACC_W-1:0] acc_d, acc_q;
    logic signed [SUM_W-1:0] fwd_s, fb_s, sum_s;

    always_comb begin
        fwd_s = SUM_W'(fwd_i >>> FWD_SH);
        fb_s  = SUM_W'(fb_i >>> FB_SH);
        sum_s = SUM_W'(acc_q) + fwd_s - fb_s;
        acc_d = acc_q;
        if (step_en) begin
            if (sum_s > SAT_HI)      acc_d = SAT_HI[ACC_W-1:0];
            else if (sum_s < SAT_LO) acc_d = SAT_LO[ACC_W-1:0];
            else                     acc_d = sum_s[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;

    // R8: no sample, no state change
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(acc_q));

    // R4: a state pinned at the upper clamp stays there while pushed further up
    p_sat_stick_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && acc_q == SAT_HI[ACC_W-1:0] && (fwd_s - fb_s) >= 0)
        |=> acc_q == $past(acc_q));

    // R4: same at the lower clamp
    p_sat_stick_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && acc_q == SAT_LO[ACC_W-1:0] && (fwd_s - fb_s) <= 0)
        |=> acc_q == $past(acc_q));
endmodule

// File: rtl/dsm4_quantizer.sv
module dsm4_quantizer #(
    parameter int ACC_W = 20,
    parameter int QNT_W = 6
) (
    input  logic signed [ACC_W-1:0] acc_i,
    output logic signed [ACC_W-1:0] fb_o,
    output logic [QNT_W-1:0]        code_o
);
    localparam int DROP = ACC_W - QNT_W;
    localparam logic [ACC_W-1:0] KEEP = {{QNT_W{1'b1}}, {DROP{1'b0}}};

    always_comb begin
        // Truncation: keep the upper bits, already aligned at their own weight.
        fb_o   = acc_i & KEEP;
        // Offset binary: flip the sign bit of the kept field.
        code_o = {~fb_o[ACC_W-1], fb_o[ACC_W-2 -: QNT_W-1]};
    end
endmodule

// File: rtl/dsm4_therm_dec.sv
module dsm4_therm_dec #(
    parameter int QNT_W = 6,
    localparam int CELLS = (1 << QNT_W) - 1
) (
    input  logic [QNT_W-1:0] code_i,
    output logic [CELLS-1:0] therm_o
);
    for (genvar j = 0; j < CELLS; j++) begin : g_cell
        assign therm_o[j] = (code_i > QNT_W'(j));
    end
endmodule

// File: rtl/dsm4_core.sv
module dsm4_core #(
    parameter int IN_W  = dsm4_pkg::DSM_IN_W,
    parameter int ACC_W = dsm4_pkg::DSM_ACC_W,
    parameter int QNT_W = dsm4_pkg::DSM_QNT_W,
    parameter int ORDER = dsm4_pkg::DSM_ORDER,
    localparam int CELLS = (1 << QNT_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [IN_W-1:0]  smp_data,
    output logic             code_valid,
    output logic [QNT_W-1:0] code_out,
    output logic [CELLS-1:0] cell_en
);
    localparam int IN_SHL = ACC_W - IN_W;
    localparam int HALF   = 1 << (QNT_W - 1);
    localparam logic [QNT_W-1:0] RST_CODE  = QNT_W'(HALF);
    localparam logic [CELLS-1:0] RST_THERM = {{(CELLS - HALF){1'b0}}, {HALF{1'b1}}};

    typedef struct packed {
        logic             step_q1;
        logic             ovld;
        logic [QNT_W-1:0] code;
        logic [CELLS-1:0] therm;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic signed [ACC_W-1:0] acc   [ORDER];
    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] fb_word;
    logic [QNT_W-1:0]        qcode;
    logic [CELLS-1:0]        tcode;

    assign x_ext = {smp_data, {IN_SHL{1'b0}}};

    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        logic signed [ACC_W-1:0] fwd;
        if (k == 0) begin : g_head
            assign fwd = x_ext;
        end else begin : g_tail
            assign fwd = acc[k-1];
        end
        dsm4_integrator #(
            .ACC_W (ACC_W),
            .FWD_SH(dsm4_pkg::fwd_shift(k)),
            .FB_SH (dsm4_pkg::fb_shift(k))
        ) integ_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .step_en(smp_valid),
            .fwd_i  (fwd),
            .fb_i   (fb_word),
            .acc_o  (acc[k])
        );
    end

    dsm4_quantizer #(.ACC_W(ACC_W), .QNT_W(QNT_W)) quant_i (
        .acc_i (acc[ORDER-1]),
        .fb_o  (fb_word),
        .code_o(qcode)
    );

    dsm4_therm_dec #(.QNT_W(QNT_W)) therm_i (
        .code_i (qcode),
        .therm_o(tcode)
    );

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.step_q1 = smp_valid;
        pipe_d.ovld    = pipe_q.step_q1;
        if (pipe_q.step_q1) begin
            pipe_d.code  = qcode;
            pipe_d.therm = tcode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q.step_q1 <= 1'b0;
            pipe_q.ovld    <= 1'b0;
            pipe_q.code    <= RST_CODE;
            pipe_q.therm   <= RST_THERM;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign code_valid = pipe_q.ovld;
    assign code_out   = pipe_q.code;
    assign cell_en    = pipe_q.therm;

    // R7: number of enabled cells equals the code
    p_cell_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cell_en) == int'(code_out));

    // R7: ones are contiguous from bit 0
    p_cell_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cell_en + CELLS'(1)) & cell_en) == '0);

    // R6: an accepted sample yields a word two edges later
    p_word_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> ##1 code_valid);

    // R8: no sample, no word; outputs hold
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ##1 (!code_valid && $stable(code_out) && $stable(cell_en)));
endmodule

// File: tb/dsm4_core_tb_top.sv
module dsm4_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [13:0] smp_data = '0;
    logic        code_valid;
    logic [5:0]  code_out;
    logic [62:0] cell_en;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;
    int a [4];

    always #5 clk = ~clk;

    dsm4_core dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .code_valid(code_valid), .code_out(code_out), .cell_en(cell_en)
    );

    function automatic int sat20(input int v);
        if (v > 524287) return 524287;
        if (v < -524288) return -524288;
        return v;
    endfunction

    function automatic logic [62:0] therm_of(input int c);
        logic [62:0] t = '0;
        for (int j = 0; j < 63; j++) t[j] = (j < c);
        return t;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [62:0] act, input logic [62:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 4; k++) a[k] = 0;
    endtask

    // Reference step from the R2..R5 recurrences; returns expected code (R6)
    function automatic int model_step(input int x);
        int q, f, n0, n1, n2, n3;
        q  = a[3] >>> 14;
        f  = q * 16384;
        n0 = sat20(a[0] + x * 64 - f);
        n1 = sat20(a[1] + (a[0] >>> 1) - (f >>> 1));
        n2 = sat20(a[2] + (a[1] >>> 2) - (f >>> 2));
        n3 = sat20(a[3] + (a[2] >>> 2) - (f >>> 3));
        a[0] = n0; a[1] = n1; a[2] = n2; a[3] = n3;
        return (n3 >>> 14) + 32;
    endfunction

    // One sample: drive, wait for the word, compare everything.
    task automatic send(input int x, input string req);
        int exp_code;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 14'(x);
        exp_code  = model_step(x);
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        check({req, " valid"}, int'(code_valid), 1);
        check({req, " code"}, int'(code_out), exp_code);
        check_vec({req, " therm R7"}, cell_en, therm_of(exp_code));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R1 valid", int'(code_valid), 0);
        check("R1 code", int'(code_out), 32);
        check_vec("R1 therm", cell_en, therm_of(32));
    endtask

    task automatic t_zero();
        for (int i = 0; i < 8; i++) send(0, "R1 zero input from cleared state");
    endtask

    task automatic t_dc_pos();
        for (int i = 0; i < 40; i++) send(2000, "R2 R3 R5 positive DC");
    endtask

    task automatic t_fullscale();
        for (int i = 0; i < 60; i++) send(-8192, "R4 negative full scale");
        for (int i = 0; i < 60; i++) send(8191, "R4 positive full scale");
    endtask

    task automatic t_ramp();
        for (int i = 0; i < 96; i++) begin
            int v = (i % 48) * 340 - 8000;
            send(v, "R3 R6 triangle ramp");
        end
    endtask

    task automatic t_idle();
        int c0;
        logic [62:0] t0;
        send(3000, "R8 pre-idle");
        c0 = int'(code_out);
        t0 = cell_en;
        repeat (6) @(negedge clk);
        check("R8 valid low when idle", int'(code_valid), 0);
        check("R8 code held", int'(code_out), c0);
        check_vec("R8 therm held", cell_en, t0);
        // State held: the next sample continues from the model's state
        for (int i = 0; i < 10; i++) send(-1500, "R8 resume after idle");
    endtask

    task automatic t_midreset();
        for (int i = 0; i < 10; i++) send(7000, "R1 before reset");
        do_reset();
        @(negedge clk);
        check("R1 code after mid reset", int'(code_out), 32);
        check("R1 valid after mid reset", int'(code_valid), 0);
        for (int i = 0; i < 5; i++) send(0, "R1 state cleared by reset");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_zero();
        t_dc_pos();
        t_fullscale();
        t_ramp();
        t_idle();
        t_midreset();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule